// File: doc/BRIEF.md
# Infrared Mark/Space Symbol Classifier

This block measures how long a synchronised infrared input stays in its active level (the mark) and how long it then stays inactive (the space). It sorts each mark/space pair into one of five programmable windows. A pair is complete only when the next mark begins, so the period of a pair is always the mark time plus the space time that follows it. Window 0 describes the leader that opens a frame. Windows 1 to 4 describe the data symbols with codes 0 to 3. A pair that fits no usable window raises an error strobe.

Each window sets a lower and an upper bound on the mark width and on the whole period. The bounds are held in pre-scaled counts. Leader bounds count in steps of 16 clock cycles. Data period bounds count in steps of 2 cycles, and data width bounds in single cycles. A control word turns the decoder on, selects which input level counts as a mark, and chooses whether a leader must come before data. Assembling symbols into words and detecting the end of a frame belong to a later stage.

Top module: `ir_symbol_classifier`

## Requirements
- R1: A pair is closed on the first clock edge that samples the start of the next mark. The pulse is the number of edges that sampled the mark. The period is that pulse plus the number of edges that sampled the space.
- R2: With `cfg_ctrl[1]` = 1, a low `ir_in` is the mark. With `cfg_ctrl[1]` = 0, a high `ir_in` is the mark.
- R3: For the leader window, the pulse and the period are each divided by 16 (floor) before comparison.
- R4: For data windows, the period is divided by 2 (floor) and the pulse is compared undivided. All bounds are inclusive at both ends.
- R5: A window matches only when both the scaled pulse and the scaled period lie within its bounds.
- R6: When several data windows match, the lowest symbol code is reported.
- R7: With `cfg_ctrl[2]` = 1, data pairs are reported only after a leader has been seen. A pair that arrives before a leader raises `err_stb`. A leader that arrives after a leader is reported again as a leader.
- R8: With `cfg_ctrl[2]` = 0, data symbols are accepted without a leader, and the leader window is never consulted.
- R9: A pair that matches no usable window pulses `err_stb` and sends the block back to waiting for a leader.
- R10: The mark and space counters saturate at 2^CNT_W-1 and do not wrap.
- R11: While `cfg_ctrl[0]` = 0 (for example, the control word is all zero), the block stays idle: it gives no strobes and discards any pair in progress. After reset, all strobes are low.
- R12: The result of a pair appears one clock after the edge that closes it, as a single-cycle pulse on exactly one of `ldr_stb`, `sym_stb` or `err_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_in | input | 1 | Infrared level, already synchronised to `clk` |
| cfg_ctrl | input | 3 | Control: bit 0 enables the decoder, bit 1 inverts the mark level, bit 2 requires a leader |
| cfg_win | input | 5*4*FIELD_W | Windows; window w sits at [w*32 +: 32] with the default field width. Window 0 is the leader and window 1+c is the data symbol with code c. Inside each window: [31:24] period max, [23:16] period min, [15:8] width max, [7:0] width min |
| ldr_stb | output | 1 | Leader recognised |
| sym_stb | output | 1 | Data symbol recognised |
| sym_code | output | 2 | Symbol code, valid while `sym_stb` is high |
| err_stb | output | 1 | Pair matched no usable window |

## Verification
The assertions check on every cycle that:
- at most one strobe fires in a cycle, and only right after a measurement is closed;
- a disabled decoder stays quiet;
- a closed measurement is never empty;
- a saturated counter stays at its maximum;
- a pair that arrives while a leader is required but none has been seen ends in an error.

Only the bench's scenarios can show the things that depend on values: the scaling of each window, the inclusive edges of the bounds, the rule that the lowest code wins when windows overlap, the inverted polarity, and the loss of a pair cut off by disabling. The bench checks these against a behavioural model, symbol by symbol and on every clock.

// File: rtl/ir_cls_pkg.sv
// Shared types and constants for the infrared symbol classifier.
package ir_cls_pkg;
    // Bit positions inside the control word
    localparam int CTRL_EN  = 0;
    localparam int CTRL_INV = 1;
    localparam int CTRL_LDR = 2;
    localparam int CTRL_W   = 3;

    // One leader window plus four data symbol windows
    localparam int NUM_DATA = 4;
    localparam int NUM_WIN  = NUM_DATA + 1;
    localparam int CODE_W   = $clog2(NUM_DATA);

    typedef enum logic [1:0] {
        MS_WAIT  = 2'd0,
        MS_MARK  = 2'd1,
        MS_SPACE = 2'd2
    } meas_st_e;

    typedef enum logic {
        CL_HUNT = 1'b0,
        CL_DATA = 1'b1
    } cls_st_e;
endpackage

// File: rtl/ir_mark_space_meter.sv
// Measures mark and space durations of a synchronised IR input.
// Assumes: ir_in is already synchronous to clk. A pair is closed when the
// next mark starts; the pulse and the pulse+space period are then presented
// for one cycle with meas_vld. Counters saturate instead of wrapping.
module ir_mark_space_meter
    import ir_cls_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             invert,
    input  logic             ir_in,
    output logic             meas_vld,
    output logic [CNT_W-1:0] meas_pulse,
    output logic [CNT_W:0]   meas_period
);
    meas_st_e         st;
    logic             act;
    logic             act_q;
    logic [CNT_W-1:0] mark_cnt;
    logic [CNT_W-1:0] space_cnt;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    // Active (mark) level after polarity selection
    assign act = ir_in ^ invert;

    // Mark/space measurement state machine
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st          <= MS_WAIT;
            act_q       <= 1'b1;
            mark_cnt    <= '0;
            space_cnt   <= '0;
            meas_vld    <= 1'b0;
            meas_pulse  <= '0;
            meas_period <= '0;
        end else begin
            act_q    <= act;
            meas_vld <= 1'b0;
            case (st)
                MS_WAIT: begin
                    if (act && !act_q) begin
                        st       <= MS_MARK;
                        mark_cnt <= CNT_W'(1);
                    end
                end
                MS_MARK: begin
                    if (act) begin
                        mark_cnt <= sat_inc(mark_cnt);
                    end else begin
                        st        <= MS_SPACE;
                        space_cnt <= CNT_W'(1);
                    end
                end
                MS_SPACE: begin
                    if (!act) begin
                        space_cnt <= sat_inc(space_cnt);
                    end else begin
                        meas_vld    <= 1'b1;
                        meas_pulse  <= mark_cnt;
                        meas_period <= {1'b0, mark_cnt} + {1'b0, space_cnt};
                        st          <= MS_MARK;
                        mark_cnt    <= CNT_W'(1);
                        space_cnt   <= '0;
                    end
                end
                default: st <= MS_WAIT;
            endcase
        end
    end

    // R1: a closed measurement holds a mark of at least one cycle and a non-empty space
    assert_meas_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        meas_vld |-> (meas_pulse != '0) && (meas_period > {1'b0, meas_pulse}));

    // R10: a full mark counter stays full while the mark lasts
    assert_mark_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == MS_MARK && act && (&mark_cnt)) |=> ((&mark_cnt) || st != MS_MARK));

    // R10: a full space counter stays full while the space lasts
    assert_space_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == MS_SPACE && !act && (&space_cnt)) |=> ((&space_cnt) || st != MS_SPACE));
endmodule

// File: rtl/ir_window_cmp.sv
// Compares one measured pair against one window.
// Assumes: the window word packs, from the top, period max, period min,
// width max and width min, each FIELD_W bits. Pulse and period are divided
// by 2**WID_SHIFT and 2**PER_SHIFT (floor) before inclusive comparison.
module ir_window_cmp #(
    parameter int CNT_W     = 16,
    parameter int FIELD_W   = 8,
    parameter int WID_SHIFT = 0,
    parameter int PER_SHIFT = 1
) (
    input  logic [4*FIELD_W-1:0] win,
    input  logic [CNT_W-1:0]     pulse,
    input  logic [CNT_W:0]       period,
    output logic                 hit
);
    localparam int CW = CNT_W + 1;

    logic [CW-1:0] wid_q, per_q;
    logic [CW-1:0] per_max, per_min, wid_max, wid_min;

    // Scale measurements and unpack the bounds
    always_comb begin
        wid_q   = CW'(pulse >> WID_SHIFT);
        per_q   = period >> PER_SHIFT;
        per_max = CW'(win[4*FIELD_W-1:3*FIELD_W]);
        per_min = CW'(win[3*FIELD_W-1:2*FIELD_W]);
        wid_max = CW'(win[2*FIELD_W-1:FIELD_W]);
        wid_min = CW'(win[FIELD_W-1:0]);
    end

    // Both the width and the period must be inside their bounds
    assign hit = (wid_q >= wid_min) && (wid_q <= wid_max) &&
                 (per_q >= per_min) && (per_q <= per_max);
endmodule

// File: rtl/ir_symbol_decider.sv
// Turns window hits of a closed pair into leader/symbol/error strobes.
// Assumes: hits are valid in the cycle meas_vld is high. Data windows are
// priority-encoded, lowest code first; strobes are registered.
module ir_symbol_decider
    import ir_cls_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                lden,
    input  logic                meas_vld,
    input  logic                ldr_hit,
    input  logic [NUM_DATA-1:0] data_hit,
    output logic                ldr_stb,
    output logic                sym_stb,
    output logic [CODE_W-1:0]   sym_code,
    output logic                err_stb
);
    cls_st_e           st;
    logic              any_data;
    logic [CODE_W-1:0] data_code;

    // Lowest matching data window wins
    always_comb begin
        data_code = '0;
        for (int i = NUM_DATA - 1; i >= 0; i--) begin
            if (data_hit[i]) data_code = CODE_W'(i);
        end
    end
    assign any_data = |data_hit;

    // Leader tracking and strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st       <= CL_HUNT;
            ldr_stb  <= 1'b0;
            sym_stb  <= 1'b0;
            err_stb  <= 1'b0;
            sym_code <= '0;
        end else begin
            ldr_stb <= 1'b0;
            sym_stb <= 1'b0;
            err_stb <= 1'b0;
            if (meas_vld) begin
                if (!lden) begin
                    if (any_data) begin
                        sym_stb  <= 1'b1;
                        sym_code <= data_code;
                    end else begin
                        err_stb <= 1'b1;
                    end
                end else if (st == CL_DATA && any_data) begin
                    sym_stb  <= 1'b1;
                    sym_code <= data_code;
                end else if (ldr_hit) begin
                    ldr_stb <= 1'b1;
                    st      <= CL_DATA;
                end else begin
                    err_stb <= 1'b1;
                    st      <= CL_HUNT;
                end
            end
        end
    end

    // R12: never more than one strobe in a cycle
    assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ldr_stb, sym_stb, err_stb}));

    // R12: strobes only follow a closed measurement
    assert_strobe_after_meas_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ldr_stb || sym_stb || err_stb) |-> $past(meas_vld));

    // R11: a disabled decoder stays silent
    assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(ldr_stb || sym_stb || err_stb));

    // R7: without a prior leader, a non-leader pair is an error
    assert_need_leader_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && lden && st == CL_HUNT && meas_vld && !ldr_hit) |=> err_stb);
endmodule

// File: rtl/ir_symbol_classifier.sv
// Top of the IR mark/space symbol classifier.
// Assumes: ir_in synchronised; cfg_win holds NUM_WIN windows, window 0 the
// leader (both fields in 16-cycle units), windows 1..4 data codes 0..3
// (period in 2-cycle units, width in cycles).
module ir_symbol_classifier
    import ir_cls_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int FIELD_W    = 8,
    parameter int LDR_SHIFT  = 4,
    parameter int DPER_SHIFT = 1,
    parameter int DWID_SHIFT = 0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ir_in,
    input  logic [CTRL_W-1:0]            cfg_ctrl,
    input  logic [NUM_WIN*4*FIELD_W-1:0] cfg_win,
    output logic                         ldr_stb,
    output logic                         sym_stb,
    output logic [CODE_W-1:0]            sym_code,
    output logic                         err_stb
);
    localparam int WIN_W = 4 * FIELD_W;

    logic               meas_vld;
    logic [CNT_W-1:0]   meas_pulse;
    logic [CNT_W:0]     meas_period;
    logic [NUM_WIN-1:0] win_hit;

    ir_mark_space_meter #(.CNT_W(CNT_W)) i_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_ctrl[CTRL_EN]),
        .invert     (cfg_ctrl[CTRL_INV]),
        .ir_in      (ir_in),
        .meas_vld   (meas_vld),
        .meas_pulse (meas_pulse),
        .meas_period(meas_period)
    );

    // One comparator per window; the leader uses its own granularity
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        ir_window_cmp #(
            .CNT_W    (CNT_W),
            .FIELD_W  (FIELD_W),
            .WID_SHIFT((w == 0) ? LDR_SHIFT : DWID_SHIFT),
            .PER_SHIFT((w == 0) ? LDR_SHIFT : DPER_SHIFT)
        ) i_cmp (
            .win   (cfg_win[w*WIN_W +: WIN_W]),
            .pulse (meas_pulse),
            .period(meas_period),
            .hit   (win_hit[w])
        );
    end

    ir_symbol_decider i_decider (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_ctrl[CTRL_EN]),
        .lden    (cfg_ctrl[CTRL_LDR]),
        .meas_vld(meas_vld),
        .ldr_hit (win_hit[0]),
        .data_hit(win_hit[NUM_WIN-1:1]),
        .ldr_stb (ldr_stb),
        .sym_stb (sym_stb),
        .sym_code(sym_code),
        .err_stb (err_stb)
    );
endmodule

// File: tb/test_ir_symbol_classifier.sv
module test_ir_symbol_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC       = 65535;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_in = 1'b0;
    logic [2:0] cfg_ctrl = 3'b000;
    logic [159:0] cfg_win;
    logic       ldr_stb, sym_stb, err_stb;
    logic [1:0] sym_code;

    int wmin[5], wmax[5], pmin[5], pmax[5];
    int checks = 0, fails = 0;
    bit inv_b = 1'b0;
    bit done = 1'b0;

    ir_symbol_classifier i_ir_symbol_classifier (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .cfg_ctrl(cfg_ctrl),
        .cfg_win(cfg_win), .ldr_stb(ldr_stb), .sym_stb(sym_stb),
        .sym_code(sym_code), .err_stb(err_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Window layout: [31:24] pmax [23:16] pmin [15:8] wmax [7:0] wmin
    always_comb begin
        for (int w = 0; w < 5; w++) begin
            cfg_win[w*32 +: 32] = {8'(pmax[w]), 8'(pmin[w]), 8'(wmax[w]), 8'(wmin[w])};
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit win_ok(int w, int p, int per);
        int wq, pq;
        wq = (w == 0) ? p / 16 : p;
        pq = (w == 0) ? per / 16 : per / 2;
        return wq >= wmin[w] && wq <= wmax[w] && pq >= pmin[w] && pq <= pmax[w];
    endfunction

    // Behavioural reference model, advanced on each rising edge
    int m_st = 0, m_mark = 0, m_space = 0, m_pp = 0, m_pper = 0;
    bit m_prev = 1'b1, m_pend = 1'b0, m_data = 1'b0;
    bit e_l = 0, e_s = 0, e_e = 0;
    int e_c = 0;
    always @(posedge clk) begin
        bit a;
        int code;
        a = ir_in ^ cfg_ctrl[1];
        if (!rst_n || !cfg_ctrl[0]) begin
            m_st = 0; m_mark = 0; m_space = 0; m_prev = 1'b1; m_pend = 1'b0;
            m_data = 1'b0; e_l = 0; e_s = 0; e_e = 0; e_c = 0;
        end else begin
            e_l = 0; e_s = 0; e_e = 0;
            if (m_pend) begin
                code = -1;
                for (int c = 3; c >= 0; c--) if (win_ok(c + 1, m_pp, m_pper)) code = c;
                if (!cfg_ctrl[2]) begin
                    if (code >= 0) begin e_s = 1; e_c = code; end else e_e = 1;
                end else if (m_data && code >= 0) begin
                    e_s = 1; e_c = code;
                end else if (win_ok(0, m_pp, m_pper)) begin
                    e_l = 1; m_data = 1'b1;
                end else begin
                    e_e = 1; m_data = 1'b0;
                end
            end
            m_pend = 1'b0;
            case (m_st)
                0: if (a && !m_prev) begin m_st = 1; m_mark = 1; end
                1: if (a) m_mark = (m_mark < MAXC) ? m_mark + 1 : MAXC;
                   else begin m_st = 2; m_space = 1; end
                default: if (!a) m_space = (m_space < MAXC) ? m_space + 1 : MAXC;
                   else begin
                       m_pend = 1'b1; m_pp = m_mark; m_pper = m_mark + m_space;
                       m_st = 1; m_mark = 1; m_space = 0;
                   end
            endcase
            m_prev = a;
        end
    end

    // Per-cycle comparison and event monitor
    int ev_cnt = 0, last_kind = 0, last_code = 0;
    always @(negedge clk) begin
        chk(ldr_stb == e_l && sym_stb == e_s && err_stb == e_e && (!e_s || sym_code == 2'(e_c)),
            "R12 per-cycle model", int'({ldr_stb, sym_stb, err_stb}), int'({e_l, e_s, e_e}));
        if (ldr_stb || sym_stb || err_stb) begin
            ev_cnt++;
            last_kind = ldr_stb ? 1 : (sym_stb ? 2 : 3);
            last_code = int'(sym_code);
        end
    end

    bit p_valid = 1'b0;
    int p_kind = 0, p_code = 0, p_n0 = 0;
    string p_tag = "";

    task automatic drive_act(bit v);
        ir_in = v ^ inv_b;
    endtask

    task automatic check_prev();
        #1;
        if (p_valid) begin
            chk(ev_cnt == p_n0 + 1, {p_tag, " event count"}, ev_cnt - p_n0, 1);
            chk(last_kind == p_kind, {p_tag, " kind"}, last_kind, p_kind);
            if (p_kind == 2) chk(last_code == p_code, {p_tag, " code"}, last_code, p_code);
        end
        p_valid = 1'b0;
    endtask

    // Send one pair; the previous pair is checked two cycles into this mark
    task automatic pair(int m, int s, int k, int c, string tag);
        drive_act(1'b1);
        @(negedge clk); @(negedge clk);
        check_prev();
        repeat (m - 2) @(negedge clk);
        drive_act(1'b0);
        repeat (s) @(negedge clk);
        p_valid = 1'b1; p_kind = k; p_code = c; p_tag = tag; p_n0 = ev_cnt;
    endtask

    task automatic flush();
        drive_act(1'b1);
        @(negedge clk); @(negedge clk);
        check_prev();
    endtask

    task automatic restart(logic [2:0] ctrl);
        drive_act(1'b0);
        repeat (4) @(negedge clk);
        cfg_ctrl = 3'b000;
        repeat (3) @(negedge clk);
        inv_b = ctrl[1];
        cfg_ctrl = ctrl;
        drive_act(1'b0);
        repeat (3) @(negedge clk);
        p_valid = 1'b0;
    endtask

    initial begin
        int n0;
        // leader: width 9..11 (x16), period 14..16 (x16)
        wmin[0] = 9;  wmax[0] = 11; pmin[0] = 14; pmax[0] = 16;
        // code 0: width 10..14, period/2 11..13
        wmin[1] = 10; wmax[1] = 14; pmin[1] = 11; pmax[1] = 13;
        // code 1: width 10..14, period/2 22..26
        wmin[2] = 10; wmax[2] = 14; pmin[2] = 22; pmax[2] = 26;
        // code 2: width 20..26, period/2 22..26
        wmin[3] = 20; wmax[3] = 26; pmin[3] = 22; pmax[3] = 26;
        // code 3: wide window overlapping the others
        wmin[4] = 10; wmax[4] = 26; pmin[4] = 11; pmax[4] = 26;

        cfg_ctrl = 3'b101;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ldr_stb && !sym_stb && !err_stb, "R11 reset state", int'({ldr_stb, sym_stb, err_stb}), 0);

        // Leader required, normal polarity
        pair(160, 80, 1, 0, "R3 leader nominal");
        pair(12, 12, 2, 0, "R6 lowest code wins");
        pair(12, 36, 2, 1, "R4 code 1");
        pair(24, 24, 2, 2, "R4 code 2");
        pair(18, 18, 2, 3, "R6 only code 3");
        pair(14, 10, 2, 0, "R4 width max inclusive");
        pair(15, 9, 2, 3, "R4 width above max");
        pair(12, 15, 2, 0, "R4 period max inclusive");
        pair(12, 16, 2, 3, "R4 period above max");
        pair(10, 12, 2, 0, "R4 minimum inclusive");
        pair(12, 60, 3, 0, "R5 period out of window");
        pair(12, 12, 3, 0, "R9 R7 data without leader");
        pair(191, 49, 1, 0, "R3 leader upper scaled");
        pair(12, 12, 2, 0, "R7 data after leader");
        pair(192, 48, 3, 0, "R3 leader width over");
        pair(144, 96, 1, 0, "R3 leader lower scaled");
        pair(160, 80, 1, 0, "R7 leader after leader");
        flush();

        // R11: cut a pair off by disabling; its close must never be reported
        drive_act(1'b0);
        repeat (20) @(negedge clk);
        #1 n0 = ev_cnt;
        cfg_ctrl = 3'b000;
        drive_act(1'b1);
        repeat (3) @(negedge clk);
        drive_act(1'b0);
        repeat (3) @(negedge clk);
        #1 chk(ev_cnt == n0, "R11 disabled stays idle", ev_cnt - n0, 0);

        // Inverted polarity, no leader required
        restart(3'b011);
        #1 n0 = ev_cnt;
        pair(12, 12, 2, 0, "R2 R8 inverted code 0");
        chk(ev_cnt == n0, "R11 dropped pair not reported", ev_cnt - n0, 0);
        pair(12, 36, 2, 1, "R8 no leader needed");
        pair(160, 80, 3, 0, "R8 leader window unused");
        pair(12, 12, 2, 0, "R8 code 0 after error");
        flush();

        // R10: an over-long mark must saturate, not wrap back to 12
        restart(3'b011);
        pair(65548, 12, 3, 0, "R10 saturated mark");
        flush();

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule